// File: doc/BRIEF.md
# Buffered Byte Serial Port

This block is a byte-wide asynchronous serial port for a small processor's peripheral bus. Software reaches it through two locations picked by `reg_sel`. Location 0 reads a status byte and writes a control byte. Location 1 reads the oldest received character and writes a character to send. Bus accesses use active-low read and write strobes, with separate input and output data buses. A write takes effect on the first clock where `n_wr` is seen low. A data read removes its character on the clock where `n_rd` returns high, so `dout` stays stable for the whole strobe.

The transmitter and receiver run on the bus clock. Each moves only on the cycles its own enable strobe (`tx_tick`, `rx_tick`) is high, and those strobes pulse at sixteen times the bit rate. A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. Received characters wait in a 16-entry queue. When the queue is close to full, `n_rts` goes high to ask the far end to pause. The transmitter has one holding byte in front of its shifter, and it starts a frame only while `n_cts` is low.

The transmitter has four states. TX_IDLE goes to TX_START when a held byte is taken while clear-to-send is asserted. TX_START goes to TX_DATA after 16 ticks. TX_DATA goes to TX_STOP after its eighth 16-tick bit. TX_STOP returns to TX_IDLE after 16 ticks. The receiver also has four states. RX_IDLE goes to RX_START on a tick that sees the line low. RX_START goes to RX_DATA if the line is still low at its eighth tick, and back to RX_IDLE if it is not. RX_DATA goes to RX_STOP after eight bits, each sampled on its sixteenth tick. RX_STOP returns to RX_IDLE on its sixteenth tick, and stores the byte if the line is high. A master reset forces both machines to their idle state from any state.

Top module: `buffered_serial_port`

## Requirements
- R1: With `reg_sel`=0 a read returns status and a write loads control. With `reg_sel`=1 a read returns the oldest received byte and a write offers a byte for sending. A write acts once per `n_wr` low pulse, and a data read removes one byte when `n_rd` rises.
- R2: Status bit 0 is 1 while the receive queue holds a byte. Bit 1 is 1 while the transmit holding byte is free. Bit 7 is the interrupt flag. Bits 2 (carrier) and 3 (clear to send) always read 0, and so do bits 6:4.
- R3: `txd` idles high. A frame is a 0 start bit, then data bits 0 to 7, then a 1 stop bit, and each bit lasts 16 `tx_tick` pulses.
- R4: Status bit 1 is 0 from a data write until the shifter takes the byte. A data write made while bit 1 is 0 is ignored and never sent.
- R5: While `n_cts` is high no new frame starts, and a held byte waits until `n_cts` goes low.
- R6: `rxd` passes through two flops. A start bit is accepted only if the line is still low on the 8th `rx_tick` after the falling edge is seen, so a shorter low pulse is ignored. Data bits are sampled 16 ticks apart. A frame whose stop bit reads 0 is discarded.
- R7: Received bytes are read back in arrival order, up to 16 waiting. A byte that completes while 16 are waiting is dropped.
- R8: `n_rts` is high while 12 or more bytes wait, or while control bits 6:5 are 10. Otherwise it is low.
- R9: Control bits 6:5 equal to 01 enable the transmit interrupt. Values 00, 10 and 11 disable it.
- R10: Status bit 7 is 1 when (control bit 7 is 1 and a byte is waiting) or (the transmit interrupt is enabled and status bit 1 is 1).
- R11: A control write with bits 1:0 = 11 empties the receive queue, discards the held transmit byte, and returns both serializers to idle by the next clock. Bits 7 and 6:5 of the same write still load.
- R12: After `rst_n` the status byte reads 0x02, `txd` is 1, `n_rts` is 0 and all interrupt enables are off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_wr | input | 1 | Active-low write strobe |
| n_rd | input | 1 | Active-low read strobe |
| reg_sel | input | 1 | 0 = status/control, 1 = data |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data to the bus |
| rx_tick | input | 1 | Receive enable, 16x bit rate |
| tx_tick | input | 1 | Transmit enable, 16x bit rate |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| n_cts | input | 1 | Active-low clear to send |
| n_rts | output | 1 | Active-low request to send |

## Verification
Transmit bytes with alternating, sparse and all-ones bit patterns show whether bit order and bit length are right. A byte written while the shifter is busy, followed by a third write, shows whether the holding slot is used and whether the extra write is dropped. On the receive side, good frames, a frame with a bad stop bit and a short low glitch are mixed. This tells apart correct start qualification, correct stop-bit checking and correct data sampling. A burst of eighteen frames with no reads covers the rising `n_rts` threshold and the drop at a full queue. Master reset is tried with a byte held back by `n_cts` and with a part-filled queue.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    // status byte bit positions (software decodes these)
    localparam int ST_RX_FULL  = 0;
    localparam int ST_TX_EMPTY = 1;
    localparam int ST_CARRIER  = 2;
    localparam int ST_CLEAR    = 3;
    localparam int ST_IRQ      = 7;

    // control byte fields
    localparam int           CTL_RX_IE    = 7;
    localparam int           CTL_TC_HI    = 6;
    localparam int           CTL_TC_LO    = 5;
    localparam logic [1:0]   CTL_MRESET   = 2'b11;
    localparam logic [1:0]   TC_TX_IE     = 2'b01;
    localparam logic [1:0]   TC_RTS_HIGH  = 2'b10;

    typedef struct packed {
        logic       rx_ie;
        logic [1:0] tc;
    } ctl_t;

endpackage

// File: rtl/bsp_sync.sv
module bsp_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RESET_VAL;
                else        chain_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bsp_tx.sv
module bsp_tx
    import bsp_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              tick,
    input  logic              cts_ok,
    input  logic              load_valid,
    input  logic [DATA_W-1:0] load_data,
    output logic              load_take,
    output logic              txd
);
    localparam int            CW        = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam int            BW        = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST_TICK = CW'(OVERSAMPLE - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(DATA_W - 1);

    tx_state_e         state_q, state_d;
    logic [CW-1:0]     tick_q;
    logic [BW-1:0]     bit_q;
    logic [DATA_W-1:0] shift_q;
    logic              bit_done;

    assign bit_done  = tick && (tick_q == LAST_TICK);
    assign load_take = (state_q == TX_IDLE) && load_valid && cts_ok && !flush;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (load_take) state_d = TX_START;
            TX_START: if (bit_done) state_d = TX_DATA;
            TX_DATA:  if (bit_done && (bit_q == LAST_BIT)) state_d = TX_STOP;
            TX_STOP:  if (bit_done) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state_q <= TX_IDLE;
        else if (flush) state_q <= TX_IDLE;
        else            state_q <= state_d;
    end

    // tick/bit counters and shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q  <= '0;
            bit_q   <= '0;
            shift_q <= '0;
        end else if (flush || (state_q == TX_IDLE)) begin
            tick_q <= '0;
            bit_q  <= '0;
            if (load_take) shift_q <= load_data;
        end else if (tick) begin
            if (bit_done) begin
                tick_q <= '0;
                if (state_q == TX_DATA) begin
                    shift_q <= shift_q >> 1;
                    bit_q   <= bit_q + 1'b1;
                end
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    // line output
    always_comb begin
        unique case (state_q)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shift_q[0];
            TX_STOP:  txd = 1'b1;
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/bsp_rx.sv
module bsp_rx
    import bsp_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              tick,
    input  logic              rx_s,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data
);
    localparam int            CW        = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam int            BW        = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST_TICK = CW'(OVERSAMPLE - 1);
    localparam logic [CW-1:0] MID_TICK  = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(DATA_W - 1);

    rx_state_e         state_q, state_d;
    logic [CW-1:0]     tick_q;
    logic [BW-1:0]     bit_q;
    logic [DATA_W-1:0] shift_q;
    logic              bit_done;
    logic              mid_start;

    assign bit_done  = tick && (tick_q == LAST_TICK);
    assign mid_start = tick && (tick_q == MID_TICK);

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (tick && !rx_s) state_d = RX_START;
            RX_START: if (mid_start) state_d = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_done && (bit_q == LAST_BIT)) state_d = RX_STOP;
            RX_STOP:  if (bit_done) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state_q <= RX_IDLE;
        else if (flush) state_q <= RX_IDLE;
        else            state_q <= state_d;
    end

    // counters and sampling shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q  <= '0;
            bit_q   <= '0;
            shift_q <= '0;
        end else if (flush || (state_q == RX_IDLE)) begin
            tick_q <= '0;
            bit_q  <= '0;
        end else if (tick) begin
            if (state_q == RX_START) begin
                tick_q <= mid_start ? '0 : tick_q + 1'b1;
            end else if (bit_done) begin
                tick_q <= '0;
                if (state_q == RX_DATA) begin
                    shift_q <= DATA_W'({rx_s, shift_q} >> 1);
                    bit_q   <= bit_q + 1'b1;
                end
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    // byte delivery
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            byte_valid <= !flush && (state_q == RX_STOP) && bit_done && rx_s;
            if ((state_q == RX_STOP) && bit_done) byte_data <= shift_q;
        end
    end
endmodule

// File: rtl/bsp_rx_fifo.sv
module bsp_rx_fifo #(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int RTS_MARGIN = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          push,
    input  logic [DATA_W-1:0]             push_data,
    input  logic                          pop,
    output logic [DATA_W-1:0]             head,
    output logic                          empty,
    output logic                          full,
    output logic                          nearly_full,
    output logic [$clog2(FIFO_DEPTH):0]   count
);
    localparam int AW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    logic [DATA_W-1:0] mem_q [FIFO_DEPTH];
    logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]     count_q;
    logic              do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full        = (count_q == CW'(FIFO_DEPTH));
    assign empty       = (count_q == '0);
    assign nearly_full = (count_q >= CW'(FIFO_DEPTH - RTS_MARGIN));
    assign do_push     = push && !full && !flush;
    assign do_pop      = pop && !empty && !flush;
    assign head        = mem_q[rd_ptr_q];
    assign count       = count_q;

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_ptr_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else if (flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= bump(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
            unique case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end
endmodule

// File: rtl/buffered_serial_port.sv
module buffered_serial_port
    import bsp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int FIFO_DEPTH  = 16,
    parameter int RTS_MARGIN  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              n_wr,
    input  logic              n_rd,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    input  logic              rx_tick,
    input  logic              tx_tick,
    input  logic              rxd,
    output logic              txd,
    input  logic              n_cts,
    output logic              n_rts
);
    localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

    // bus strobe edges
    logic wr_q, rd_q;
    logic ctl_wr, data_wr, data_rd, ctl_reset;

    // control and transmit holding byte
    ctl_t              ctl_q;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              tx_take;
    logic              cts_s, rx_s;

    // receive side
    logic              rx_push;
    logic [DATA_W-1:0] rx_data;
    logic              fifo_empty, fifo_full, fifo_high;
    logic [DATA_W-1:0] fifo_head;
    logic [CNT_W-1:0]  fifo_count;

    logic              tx_irq_en, rts_forced, irq;
    logic [DATA_W-1:0] status;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= 1'b1;
            rd_q <= 1'b1;
        end else begin
            wr_q <= n_wr;
            rd_q <= n_rd;
        end
    end

    assign ctl_wr    = !n_wr && wr_q && !reg_sel;
    assign data_wr   = !n_wr && wr_q && reg_sel;
    assign data_rd   = n_rd && !rd_q && reg_sel;
    assign ctl_reset = ctl_wr && (din[1:0] == CTL_MRESET);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q.rx_ie <= din[CTL_RX_IE];
            ctl_q.tc    <= din[CTL_TC_HI:CTL_TC_LO];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (ctl_reset) begin
            hold_full <= 1'b0;
        end else if (data_wr && !hold_full) begin
            hold_full <= 1'b1;
            hold_data <= din;
        end else if (tx_take) begin
            hold_full <= 1'b0;
        end
    end

    bsp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cts_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (n_cts),
        .q     (cts_s)
    );

    bsp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_rxd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rxd),
        .q     (rx_s)
    );

    bsp_tx #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (ctl_reset),
        .tick       (tx_tick),
        .cts_ok     (!cts_s),
        .load_valid (hold_full),
        .load_data  (hold_data),
        .load_take  (tx_take),
        .txd        (txd)
    );

    bsp_rx #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (ctl_reset),
        .tick       (rx_tick),
        .rx_s       (rx_s),
        .byte_valid (rx_push),
        .byte_data  (rx_data)
    );

    bsp_rx_fifo #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .RTS_MARGIN(RTS_MARGIN)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (ctl_reset),
        .push        (rx_push),
        .push_data   (rx_data),
        .pop         (data_rd),
        .head        (fifo_head),
        .empty       (fifo_empty),
        .full        (fifo_full),
        .nearly_full (fifo_high),
        .count       (fifo_count)
    );

    assign tx_irq_en  = (ctl_q.tc == TC_TX_IE);
    assign rts_forced = (ctl_q.tc == TC_RTS_HIGH);
    assign irq        = (ctl_q.rx_ie && !fifo_empty) || (tx_irq_en && !hold_full);
    assign n_rts      = rts_forced || fifo_high;

    always_comb begin
        status              = '0;
        status[ST_RX_FULL]  = !fifo_empty;
        status[ST_TX_EMPTY] = !hold_full;
        status[ST_CARRIER]  = 1'b0;
        status[ST_CLEAR]    = 1'b0;
        status[ST_IRQ]      = irq;
    end

    assign dout = reg_sel ? fifo_head : status;
endmodule

// File: rtl/bsp_chk.sv
module bsp_chk #(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int RTS_MARGIN = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_sel,
    input logic [DATA_W-1:0]           dout,
    input logic                        txd,
    input logic                        n_cts,
    input logic                        n_rts,
    input logic                        ctl_reset,
    input logic                        data_wr,
    input logic                        data_rd,
    input logic                        hold_full,
    input logic [DATA_W-1:0]           hold_data,
    input logic                        tx_take,
    input logic                        rx_push,
    input logic                        fifo_full,
    input logic [$clog2(FIFO_DEPTH):0] fifo_count
);
    localparam int CW = $clog2(FIFO_DEPTH) + 1;
    localparam logic [CW-1:0] MARK = CW'(FIFO_DEPTH - RTS_MARGIN);

    // R2
    status_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (dout[6:2] == '0));

    // R4
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && hold_full && !tx_take && !ctl_reset) |=> (hold_full && $stable(hold_data)));

    // R5
    cts_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (n_cts && $past(n_cts) && $past(n_cts, 2)) |-> !tx_take);

    // R7
    fifo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && fifo_full && !data_rd && !ctl_reset) |=> $stable(fifo_count));

    // R8
    rts_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count >= MARK) |-> n_rts);

    // R11
    master_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_reset |=> ((fifo_count == '0) && !hold_full && txd));
endmodule

bind buffered_serial_port bsp_chk #(
    .DATA_W     (DATA_W),
    .FIFO_DEPTH (FIFO_DEPTH),
    .RTS_MARGIN (RTS_MARGIN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .dout       (dout),
    .txd        (txd),
    .n_cts      (n_cts),
    .n_rts      (n_rts),
    .ctl_reset  (ctl_reset),
    .data_wr    (data_wr),
    .data_rd    (data_rd),
    .hold_full  (hold_full),
    .hold_data  (hold_data),
    .tx_take    (tx_take),
    .rx_push    (rx_push),
    .fifo_full  (fifo_full),
    .fifo_count (fifo_count)
);

// File: tb/test_buffered_serial_port.sv
module test_buffered_serial_port;
    localparam int TICK_DIV = 4;
    localparam int BIT_CYC  = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       n_wr = 1'b1;
    logic       n_rd = 1'b1;
    logic       reg_sel = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic       txd;
    logic       n_cts = 1'b0;
    logic       n_rts;

    int n_total = 0;
    int n_bad = 0;
    int rx_model = 0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    // 125 MHz: 8 time-unit period
    always #4 clk = ~clk;

    buffered_serial_port i_buffered_serial_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .n_wr    (n_wr),
        .n_rd    (n_rd),
        .reg_sel (reg_sel),
        .din     (din),
        .dout    (dout),
        .rx_tick (tick),
        .tx_tick (tick),
        .rxd     (rxd),
        .txd     (txd),
        .n_cts   (n_cts),
        .n_rts   (n_rts)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic sel, input logic [7:0] v);
        @(negedge clk);
        reg_sel = sel;
        din     = v;
        n_wr    = 1'b0;
        @(negedge clk);
        n_wr = 1'b1;
        @(negedge clk);
    endtask

    task automatic cpu_read(input logic sel, output logic [7:0] v);
        @(negedge clk);
        reg_sel = sel;
        n_rd    = 1'b0;
        @(negedge clk);
        v    = dout;
        n_rd = 1'b1;
        @(negedge clk);
    endtask

    // driver for the receive side: pushes the expected byte if it should be kept
    task automatic send_frame(input logic [7:0] b, input logic stop_val);
        if (stop_val && rx_model < 16) begin
            rx_q.push_back(b);
            rx_model++;
        end
        @(negedge clk);
        rxd = 1'b0;
        repeat (BIT_CYC - 1) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BIT_CYC) @(negedge clk);
        end
        rxd = stop_val;
        repeat (BIT_CYC) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT_CYC) @(negedge clk);
    endtask

    // monitor for the receive side: reads one byte and compares with the queue
    task automatic read_rx(input string req);
        logic [7:0] v;
        logic [7:0] exp;
        cpu_read(1'b1, v);
        exp = (rx_q.size() != 0) ? rx_q.pop_front() : 8'hxx;
        if (rx_model > 0) rx_model--;
        check(req, v, exp);
    endtask

    task automatic wait_drain();
        while (tx_q.size() != 0) @(negedge clk);
        repeat (BIT_CYC) @(negedge clk);
    endtask

    initial begin : tick_gen
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            cnt  = (cnt == TICK_DIV - 1) ? 0 : cnt + 1;
            tick = (cnt == 0);
        end
    end

    // line monitor for the transmitter
    initial begin : tx_monitor
        logic [7:0] got;
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                repeat (BIT_CYC / 2) @(negedge clk);
                check("R3 start bit", {31'd0, txd}, 32'd0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BIT_CYC) @(negedge clk);
                    got[i] = txd;
                end
                repeat (BIT_CYC) @(negedge clk);
                check("R3 stop bit", {31'd0, txd}, 32'd1);
                if (tx_q.size() == 0) begin
                    n_total++;
                    n_bad++;
                    $display("FAIL R4 unexpected frame: actual=%0h expected=none", got);
                end else begin
                    check("R3 transmitted byte", {24'd0, got}, {24'd0, tx_q.pop_front()});
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_total++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        int         held;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R12 reset state
        cpu_read(1'b0, v);
        check("R12 status after reset", v, 8'h02);
        check("R2 status bits 6:2 zero", v[6:2], 0);
        check("R12 txd idle high", txd, 1);
        check("R12 n_rts low", n_rts, 0);

        // R3 R1 single byte
        tx_q.push_back(8'hA5);
        cpu_write(1'b1, 8'hA5);
        wait_drain();

        // R4 holding slot and ignored extra write
        tx_q.push_back(8'h3C);
        cpu_write(1'b1, 8'h3C);
        repeat (10) @(negedge clk);
        tx_q.push_back(8'h01);
        cpu_write(1'b1, 8'h01);
        cpu_write(1'b1, 8'hFF);
        cpu_read(1'b0, v);
        check("R4 tx holding byte busy", v[1], 0);
        wait_drain();
        cpu_read(1'b0, v);
        check("R4 tx holding byte free again", v[1], 1);

        // R5 clear-to-send gating
        n_cts = 1'b1;
        repeat (10) @(negedge clk);
        tx_q.push_back(8'h5A);
        cpu_write(1'b1, 8'h5A);
        held = 1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) held = 0;
        end
        check("R5 txd quiet while n_cts high", held, 1);
        cpu_read(1'b0, v);
        check("R5 byte still waiting", v[1], 0);
        n_cts = 1'b0;
        wait_drain();

        // R11 master reset drops the held byte
        n_cts = 1'b1;
        repeat (10) @(negedge clk);
        cpu_write(1'b1, 8'h77);
        cpu_write(1'b0, 8'h03);
        cpu_read(1'b0, v);
        check("R11 status after master reset", v, 8'h02);
        n_cts = 1'b0;
        held = 1;
        for (int i = 0; i < 800; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) held = 0;
        end
        check("R11 discarded byte never sent", held, 1);

        // R9 R10 R8 transmitter control decode
        cpu_write(1'b0, 8'h20);
        cpu_read(1'b0, v);
        check("R9 tx interrupt on with 01", v, 8'h82);
        check("R8 n_rts low with 01", n_rts, 0);
        cpu_write(1'b0, 8'h40);
        cpu_read(1'b0, v);
        check("R9 tx interrupt off with 10", v, 8'h02);
        check("R8 n_rts forced high with 10", n_rts, 1);
        cpu_write(1'b0, 8'h60);
        cpu_read(1'b0, v);
        check("R9 tx interrupt off with 11", v, 8'h02);
        check("R8 n_rts low with 11", n_rts, 0);
        cpu_write(1'b0, 8'h80);
        cpu_read(1'b0, v);
        check("R10 no irq with empty queue", v, 8'h02);

        // R6 R10 R1 receive path
        send_frame(8'hC3, 1'b1);
        cpu_read(1'b0, v);
        check("R10 rx irq with byte waiting", v, 8'h83);
        send_frame(8'h5E, 1'b1);
        send_frame(8'h99, 1'b0);
        send_frame(8'h00, 1'b1);
        read_rx("R1 first received byte");
        read_rx("R6 byte after good frame");
        read_rx("R6 bad-stop frame skipped");
        cpu_read(1'b0, v);
        check("R1 queue empty after reads", v, 8'h02);

        // R6 short glitch rejected
        @(negedge clk);
        rxd = 1'b0;
        repeat (16) @(negedge clk);
        rxd = 1'b1;
        repeat (300) @(negedge clk);
        cpu_read(1'b0, v);
        check("R6 glitch ignored", v, 8'h02);

        // R7 R8 fill past capacity
        cpu_write(1'b0, 8'h00);
        for (int k = 1; k <= 18; k++) begin
            send_frame(8'h10 + 8'(k), 1'b1);
            check("R8 n_rts against queue level", n_rts, (k >= 12) ? 1 : 0);
        end
        for (int k = 0; k < 16; k++) read_rx("R7 order kept and overflow dropped");
        cpu_read(1'b0, v);
        check("R7 queue empty after 16 reads", v, 8'h02);
        check("R8 n_rts released", n_rts, 0);

        // R11 master reset empties the queue
        rx_model = 0;
        send_frame(8'hAA, 1'b1);
        send_frame(8'hBB, 1'b1);
        rx_q.delete();
        rx_model = 0;
        cpu_write(1'b0, 8'h03);
        cpu_read(1'b0, v);
        check("R11 queue flushed", v, 8'h02);
        send_frame(8'h42, 1'b1);
        read_rx("R11 queue usable after reset");

        repeat (20) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule